// File: doc/BRIEF.md
# Flash Window Chip-Select Segment Decoder

This block sits in front of a memory-mapped serial flash controller. The controller owns a 256 MB aperture in the system address map, starting at a fixed base. Software divides that aperture among up to three attached flash devices by writing one segment register per chip select. Each segment register gives a start and an inclusive end, both counted in 1 MB steps from the aperture base.

On every cycle with a valid bus address, the decoder reports three things one clock later. It says whether the address falls inside the aperture, which chip select it targets (if any), and the byte offset inside that device. An address inside the aperture that no enabled segment covers raises a miss flag. A register of all zeros disables its segment. Where segments overlap, the lower-numbered chip select is chosen.

A read-only configuration word reports a fixed device-type code for every chip select. The start of chip select 0 is pinned at offset 0 and cannot be written.

Top module: `seg_decoder`

## Requirements
- R1: After reset, the segment register of chip select 0 reads 0x07F0_0000, which covers offsets 0 to 128 MB. Every other segment register reads 0.
- R2: Register index 0 reads code 2'b10 in bits [2k+1:2k] for each chip select k, with all other bits zero (0x0000_002A for three chip selects). Writes to index 0 have no effect.
- R3: The segment register of chip select k sits at index k+1. Its end field is bits [27:20] and its start field is bits [11:4], both in 1 MB units. All other bits read as zero and ignore writes.
- R4: The start field of chip select 0 always reads zero, whatever is written to it.
- R5: `winHit` is high one cycle after a valid address with WIN_BASE <= addr < WIN_BASE + 0x1000_0000. An address outside that range yields no hit, no chip select and no miss.
- R6: A segment matches when the 1 MB index of (addr - WIN_BASE) is at least the start field and at most the end field. The end bound is inclusive. On a match, `csSel` is one-hot on that chip select.
- R7: When a chip select is selected, `devOffset` equals (addr - WIN_BASE) - start*1 MB over 28 bits. Otherwise it is zero.
- R8: A segment register holding all zeros matches no address.
- R9: When several enabled segments match, only the lowest-numbered chip select is selected. `csSel` is never more than one-hot.
- R10: A valid address inside the aperture that matches no enabled segment gives `segMiss`=1 and `csSel`=0 one cycle later.
- R11: Decode outputs are registered with one cycle of latency. After a cycle with `addrValid` low, `winHit`, `csSel`, `segMiss` and `devOffset` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regIdx | input | IDX_W | Register index: 0 is configuration, k+1 is the segment of chip select k |
| regWe | input | 1 | Register write enable |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regIdx`, combinational |
| addrValid | input | 1 | Bus address valid |
| addr | input | 32 | Bus address |
| winHit | output | 1 | Registered: address was inside the aperture |
| csSel | output | NUM_CS | Registered one-hot chip select |
| segMiss | output | 1 | Registered: inside the aperture but no segment matched |
| devOffset | output | 28 | Registered byte offset inside the selected device |

## Verification
Several properties are checked on every cycle: `csSel` stays at most one-hot, a miss never comes with a chip select or without an aperture hit, and a chip select never appears outside the aperture. Two more hold on every cycle: idle cycles give zero outputs, and readback never shows bits outside the two fields or a nonzero start for chip select 0. Other behaviour only the bench scenarios can show. This covers the inclusive end bound at exact boundary addresses, the offset arithmetic, and lowest-index priority in an overlap. It also covers disabling a segment by writing zero and the reset contents of the registers.

// File: rtl/seg_decoder_pkg.sv
package seg_decoder_pkg;
  localparam int MAX_CS   = 3;
  localparam int MB_SHIFT = 20;
  localparam int WIN_BITS = 28;
  localparam int FLD_W    = WIN_BITS - MB_SHIFT;

  typedef struct packed {
    logic [MAX_CS-1:0] segWr;   // write strobe per chip select
    logic              cfgWr;   // write aimed at the read-only config word
    logic              decEn;   // capture a decode result this cycle
  } ctrlStrobes_t;
endpackage

// File: rtl/seg_decoder_ctrl.sv
module seg_decoder_ctrl
  import seg_decoder_pkg::*;
#(
  parameter int NUM_CS = 3,
  parameter int IDX_W  = 2
) (
  input  logic             regWe,
  input  logic [IDX_W-1:0] regIdx,
  input  logic             addrValid,
  output ctrlStrobes_t     strobes
);
  always_comb begin
    strobes       = '0;
    strobes.decEn = addrValid;
    strobes.cfgWr = regWe && (regIdx == '0);
    for (int k = 0; k < NUM_CS; k++) begin
      strobes.segWr[k] = regWe && (int'(regIdx) == k + 1);
    end
  end
endmodule

// File: rtl/seg_decoder_dp.sv
module seg_decoder_dp
  import seg_decoder_pkg::*;
#(
  parameter int          NUM_CS   = 3,
  parameter int          IDX_W    = 2,
  parameter logic [31:0] WIN_BASE = 32'h2000_0000,
  parameter logic [FLD_W-1:0] CS0_END = 8'h7F
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [IDX_W-1:0]    regIdx,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  input  logic [31:0]         addr,
  output logic                winHit,
  output logic [NUM_CS-1:0]   csSel,
  output logic                segMiss,
  output logic [WIN_BITS-1:0] devOffset
);
  localparam logic [31:0] CFG_WORD = cfgWord();

  function automatic logic [31:0] cfgWord();
    logic [31:0] w = '0;
    for (int k = 0; k < NUM_CS; k++) w[2*k +: 2] = 2'b10;
    return w;
  endfunction

  logic [FLD_W-1:0] segStart [NUM_CS];
  logic [FLD_W-1:0] segEnd   [NUM_CS];

  // segment storage; chip select 0 keeps a fixed zero start
  for (genvar k = 0; k < NUM_CS; k++) begin : gSeg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        segEnd[k] <= (k == 0) ? CS0_END : '0;
      end else if (strobes.segWr[k]) begin
        segEnd[k] <= regWdata[WIN_BITS-1:MB_SHIFT];
      end
    end
    if (k == 0) begin : gFixed
      assign segStart[k] = '0;
    end else begin : gWritable
      always_ff @(posedge clk) begin
        if (!rstN) segStart[k] <= '0;
        else if (strobes.segWr[k]) segStart[k] <= regWdata[4 +: FLD_W];
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (regIdx == '0) regRdata = CFG_WORD;
    for (int k = 0; k < NUM_CS; k++) begin
      if (int'(regIdx) == k + 1)
        regRdata = {4'b0, segEnd[k], 8'b0, segStart[k], 4'b0};
    end
  end

  // address compare
  logic [31:0]         relAddr;
  logic                inWin;
  logic [FLD_W-1:0]    relMb;
  logic [NUM_CS-1:0]   matchVec;
  logic [NUM_CS-1:0]   pickVec;
  logic [WIN_BITS-1:0] pickOff;

  assign relAddr = addr - WIN_BASE;
  assign inWin   = (addr >= WIN_BASE) && (relAddr[31:WIN_BITS] == '0);
  assign relMb   = relAddr[WIN_BITS-1:MB_SHIFT];

  for (genvar k = 0; k < NUM_CS; k++) begin : gMatch
    assign matchVec[k] = ((segStart[k] | segEnd[k]) != '0)
                       && (relMb >= segStart[k]) && (relMb <= segEnd[k]);
  end

  always_comb begin
    pickVec = '0;
    pickOff = '0;
    for (int k = NUM_CS - 1; k >= 0; k--) begin
      if (matchVec[k]) begin
        pickVec    = '0;
        pickVec[k] = 1'b1;
        pickOff    = relAddr[WIN_BITS-1:0] - {segStart[k], {MB_SHIFT{1'b0}}};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobes.decEn || !inWin) begin
      winHit    <= 1'b0;
      csSel     <= '0;
      segMiss   <= 1'b0;
      devOffset <= '0;
    end else begin
      winHit    <= 1'b1;
      csSel     <= pickVec;
      segMiss   <= (pickVec == '0);
      devOffset <= pickOff;
    end
  end
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import seg_decoder_pkg::*;
#(
  parameter int          NUM_CS   = 3,
  parameter logic [31:0] WIN_BASE = 32'h2000_0000,
  localparam int         IDX_W    = $clog2(NUM_CS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [IDX_W-1:0]    regIdx,
  input  logic                regWe,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  input  logic                addrValid,
  input  logic [31:0]         addr,
  output logic                winHit,
  output logic [NUM_CS-1:0]   csSel,
  output logic                segMiss,
  output logic [WIN_BITS-1:0] devOffset
);
  ctrlStrobes_t strobes;

  seg_decoder_ctrl #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) uCtrl (
    .regWe(regWe), .regIdx(regIdx), .addrValid(addrValid), .strobes(strobes)
  );

  seg_decoder_dp #(.NUM_CS(NUM_CS), .IDX_W(IDX_W), .WIN_BASE(WIN_BASE)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regIdx(regIdx),
    .regWdata(regWdata), .regRdata(regRdata), .addr(addr),
    .winHit(winHit), .csSel(csSel), .segMiss(segMiss), .devOffset(devOffset)
  );
endmodule

// File: rtl/seg_decoder_chk.sv
module seg_decoder_chk #(
  parameter int          NUM_CS   = 3,
  parameter logic [31:0] WIN_BASE = 32'h2000_0000,
  parameter int          IDX_W    = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [IDX_W-1:0]  regIdx,
  input logic [31:0]       regRdata,
  input logic              addrValid,
  input logic [31:0]       addr,
  input logic              winHit,
  input logic [NUM_CS-1:0] csSel,
  input logic              segMiss,
  input logic [27:0]       devOffset
);
  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(csSel));

  assert_miss_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    segMiss |-> (csSel == '0) && winHit);

  assert_cs_in_win_R5: assert property (@(posedge clk) disable iff (!rstN)
    (csSel != '0) |-> winHit);

  assert_below_base_R5: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && addr < WIN_BASE) |=> !winHit && !segMiss);

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> !winHit && (csSel == '0) && !segMiss && (devOffset == '0));

  assert_fields_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regIdx != '0) |-> (regRdata & 32'hF00F_F00F) == '0);

  assert_cs0_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    (int'(regIdx) == 1) |-> regRdata[11:4] == 8'h00);
endmodule

bind seg_decoder seg_decoder_chk #(.NUM_CS(NUM_CS), .WIN_BASE(WIN_BASE), .IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .regIdx(regIdx), .regRdata(regRdata),
  .addrValid(addrValid), .addr(addr), .winHit(winHit), .csSel(csSel),
  .segMiss(segMiss), .devOffset(devOffset)
);

// File: tb/sim_seg_decoder.sv
`timescale 1ns/1ps
module sim_seg_decoder;
  localparam int NV = 10;
  // decode vectors: address, {hit, csSel[2:0], miss}, offset
  localparam logic [31:0] V_ADDR [NV] = '{
    32'h2000_0000, 32'h27FF_FFFC, 32'h2800_0000, 32'h2B12_3456, 32'h2C00_0010,
    32'h2CFF_FFFF, 32'h2D00_0000, 32'h2FFF_FFFF, 32'h1FFF_FFFF, 32'h3000_0000};
  localparam logic [4:0] V_FLG [NV] = '{
    5'b10010, 5'b10010, 5'b10100, 5'b10100, 5'b11000,
    5'b11000, 5'b10001, 5'b10001, 5'b00000, 5'b00000};
  localparam logic [27:0] V_OFF [NV] = '{
    28'h0, 28'h7FF_FFFC, 28'h0, 28'h312_3456, 28'h100_0010,
    28'h1FF_FFFF, 28'h0, 28'h0, 28'h0, 28'h0};
  localparam string V_TAG [NV] = '{"R6", "R6", "R6", "R9", "R7",
    "R6", "R10", "R10", "R5", "R5"};

  logic clk = 0, rstN = 0;
  logic [1:0] regIdx = 0;
  logic regWe = 0, addrValid = 0;
  logic [31:0] regWdata = 0, addr = 0, regRdata;
  logic winHit, segMiss;
  logic [2:0] csSel;
  logic [27:0] devOffset;
  int nChk = 0, nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seg_decoder u0 (.clk(clk), .rstN(rstN), .regIdx(regIdx), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .addrValid(addrValid), .addr(addr),
    .winHit(winHit), .csSel(csSel), .segMiss(segMiss), .devOffset(devOffset));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wrReg(logic [1:0] idx, logic [31:0] d);
    @(negedge clk); regIdx = idx; regWdata = d; regWe = 1;
    @(negedge clk); regWe = 0;
  endtask

  task automatic rdReg(logic [1:0] idx, output logic [31:0] d);
    @(negedge clk); regIdx = idx; #1 d = regRdata;
  endtask

  // present one address for one cycle; sample at the next falling edge
  task automatic decode(logic [31:0] a, output logic [4:0] f, output logic [27:0] o);
    @(negedge clk); addr = a; addrValid = 1;
    @(negedge clk); addrValid = 0;
    f = {winHit, csSel, segMiss}; o = devOffset;
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      finishRun();
    end
  end

  initial begin
    logic [31:0] r;
    logic [4:0] f;
    logic [27:0] o;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset contents
    rdReg(1, r); chk("R1 cs0 reset", r, 32'h07F0_0000);
    rdReg(2, r); chk("R1 cs1 reset", r, 32'h0);
    rdReg(3, r); chk("R1 cs2 reset", r, 32'h0);
    chk("R11 idle outputs", {winHit, csSel, segMiss, devOffset}, 0);
    // R2 config word, write ignored
    rdReg(0, r); chk("R2 cfg", r, 32'h0000_002A);
    wrReg(0, 32'hFFFF_FFFF);
    rdReg(0, r); chk("R2 cfg after write", r, 32'h0000_002A);
    // R4 cs0 start read-only
    wrReg(1, 32'h0FF0_0FF0);
    rdReg(1, r); chk("R4 cs0 start fixed", r, 32'h0FF0_0000);
    wrReg(1, 32'h07F0_0000);
    // R3 unused bits dropped
    wrReg(2, 32'hFBF0_F80F);
    rdReg(2, r); chk("R3 cs1 masked", r, 32'h0BF0_0800);
    wrReg(3, 32'h0CF0_0B00);
    rdReg(3, r); chk("R3 cs2 readback", r, 32'h0CF0_0B00);
    // vector table
    for (int i = 0; i < NV; i++) begin
      decode(V_ADDR[i], f, o);
      chk({V_TAG[i], " flags"}, {27'b0, f}, {27'b0, V_FLG[i]});
      chk({V_TAG[i], " offset"}, {4'b0, o}, {4'b0, V_OFF[i]});
    end
    // R11 outputs clear one cycle after valid drops
    @(negedge clk);
    chk("R11 cleared", {winHit, csSel, segMiss, devOffset}, 0);
    // R11 latency: output still zero before the edge that captures
    @(negedge clk); addr = 32'h2800_0040; addrValid = 1; #1;
    chk("R11 not yet", {28'b0, csSel, winHit}, 0);
    @(negedge clk); addrValid = 0;
    chk("R11 one cycle", {28'b0, csSel, winHit}, 32'h5);
    // R8 disabled segment
    wrReg(3, 32'h0);
    decode(32'h2C00_0010, f, o);
    chk("R8 disabled cs2", {27'b0, f}, 32'h11);
    // R6 inclusive end of cs1 and first MB past it
    decode(32'h2BFF_FFFF, f, o);
    chk("R6 cs1 last byte", {27'b0, f}, 32'h14);
    decode(32'h2C00_0000, f, o);
    chk("R10 past cs1 end", {27'b0, f}, 32'h11);
    done = 1;
    finishRun();
  end
endmodule